// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Bus Controller

This block is the slave-side front end of a two-wire serial memory. It samples the clock line and the data line with the system clock. It finds start and stop conditions and shifts in bytes on rising edges of the bus clock. It pulls the data line low in the ninth clock to acknowledge a byte. The storage array sits outside the block. The block reaches it through a byte-wide port with a write strobe and a read strobe.

A transfer opens with a start and a device-select byte. The upper seven bits of that byte must equal a fixed device code, and the lowest bit selects read (1) or write (0). A write carries a word address byte and then data bytes, each written to the array at an auto-incrementing pointer. A read streams bytes from the pointer, most significant bit first, for as long as the master acknowledges. A stop that closes a write in which data was stored launches a timed internal write cycle. While that cycle runs, the block raises a busy flag and ignores the bus completely.

Top module: `eeb_slave_top`

## Requirements
- R1: A start is a falling data line while the clock line is high, and a stop is a rising data line while the clock line is high. Bytes clocked without a preceding start are not acknowledged.
- R2: Bits are sampled on rising clock-line edges, most significant bit first. In the first byte after a start, bits [7:1] are compared with DEV_CODE, and bit 0 = 1 selects read.
- R3: After a matching device byte, an address byte or a write data byte, the block pulls the data line low for the ninth clock. After a mismatching device byte it gives no acknowledge and stays silent until the next start.
- R4: The second byte of a write loads the pointer from its low ADDR_W bits. Each later data byte gives a one-cycle mem_wr_en_o at the pointer, and the pointer then advances by one, wrapping at 2^ADDR_W.
- R5: A read pulses mem_rd_en_o and captures mem_rd_data_i on the following clock cycle. The byte is shifted out MSB first, with the data line changed only while the clock line is low, and the line is released in the ninth clock. The pointer advances by one after every byte sent, wrapping.
- R6: A master acknowledge (data low in the ninth clock) continues the read with the next byte. A no-acknowledge puts the block in standby: it drives nothing on further clocks until a stop or start.
- R7: A stop that ends a write in which at least one data byte was stored raises busy_o for exactly WRITE_CYCLES clock cycles. A stop after only device and address bytes raises no busy.
- R8: While busy_o is high, starts are ignored, no byte is acknowledged and no memory strobe is given.
- R9: A start in the middle of a transfer (repeated start) clears the bit count, even partway through a byte, and expects a new device byte.
- R10: After reset, sda_oe_o, busy_o, mem_wr_en_o and mem_rd_en_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| mem_addr_o | output | ADDR_W | Array address (pointer) |
| mem_wr_en_o | output | 1 | One-cycle array write strobe |
| mem_wr_data_o | output | 8 | Byte to write |
| mem_rd_en_o | output | 1 | One-cycle array read strobe |
| mem_rd_data_i | input | 8 | Read byte, valid the cycle after mem_rd_en_o |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
Several properties are checked on every cycle: the data-line drive changes only while the synchronized clock line is low, write strobes last one cycle and never coincide with read strobes, and busy rises only after a launch. During busy no drive and no write strobe occur. Only the bench scenarios can show the rest. These are the device-code comparison, address wrap across the top of the array, the read stream after a repeated start, standby after a no-acknowledge, the exact length of the write cycle and the contents read back from every address.

// File: rtl/eeb_pkg.sv
package eeb_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_WAIT_STOP
   } eeb_state_t;

   localparam int EEB_BYTE_BITS = 8;

endpackage

// File: rtl/eeb_line_sync.sv
module eeb_line_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);

   initial begin
      assert (STAGES >= 2) else $error("eeb_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{RESET_VAL}};
         prev <= RESET_VAL;
      end else begin
         pipe <= {pipe[STAGES-2:0], din};
         prev <= pipe[STAGES-1];
      end
   end

   assign lvl_o  = pipe[STAGES-1];
   assign rise_o = pipe[STAGES-1] & ~prev;
   assign fall_o = ~pipe[STAGES-1] & prev;

endmodule

// File: rtl/eeb_write_timer.sv
module eeb_write_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   output logic busy_o
);

   initial begin
      assert (CYCLES >= 1) else $error("eeb_write_timer: CYCLES must be at least 1");
   end

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt != '0) begin
         cnt <= cnt - CW'(1);
      end else if (launch_i) begin
         cnt <= CW'(CYCLES);
      end
   end

   assign busy_o = (cnt != '0);

   assert_busy_after_launch_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (launch_i && !busy_o) |=> busy_o);

   assert_busy_cause_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(launch_i));

endmodule

// File: rtl/eeb_byte_engine.sv
module eeb_byte_engine
   import eeb_pkg::*;
#(
   parameter logic [6:0] DEV_CODE = 7'h50,
   parameter int         ADDR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic              busy,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_wr_en,
   output logic [7:0]        mem_wr_data,
   output logic              mem_rd_en,
   input  logic [7:0]        mem_rd_data,
   output logic              launch
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= EEB_BYTE_BITS)
         else $error("eeb_byte_engine: ADDR_W must be 1..8");
   end

   localparam logic [3:0] LAST_BIT = 4'(EEB_BYTE_BITS);

   eeb_state_t        state;
   logic [3:0]        bit_cnt;
   logic [7:0]        rx_shift;
   logic [7:0]        tx_shift;
   logic [ADDR_W-1:0] addr_ptr;
   logic              is_read;
   logic              dirty;
   logic              got_ack;
   logic              rd_req;
   logic              rd_cap;
   logic              oe_q;
   logic              wr_q;
   logic [7:0]        wdata_q;
   logic              launch_q;

   logic start_det;
   logic stop_det;
   logic byte_end;

   assign start_det = sda_fall & scl_lvl;
   assign stop_det  = sda_rise & scl_lvl;
   assign byte_end  = scl_fall && (bit_cnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         rx_shift <= '0;
         tx_shift <= '0;
         addr_ptr <= '0;
         is_read  <= 1'b0;
         dirty    <= 1'b0;
         got_ack  <= 1'b0;
         rd_req   <= 1'b0;
         rd_cap   <= 1'b0;
         oe_q     <= 1'b0;
         wr_q     <= 1'b0;
         wdata_q  <= '0;
         launch_q <= 1'b0;
      end else begin
         wr_q     <= 1'b0;
         rd_req   <= 1'b0;
         launch_q <= 1'b0;
         rd_cap   <= rd_req;
         if (rd_cap) begin
            tx_shift <= mem_rd_data;
         end

         if (busy) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
            dirty <= 1'b0;
         end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
            dirty   <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            oe_q     <= 1'b0;
            launch_q <= dirty;
            dirty    <= 1'b0;
         end else begin
            case (state)
               ST_DEV, ST_ADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     rx_shift <= {rx_shift[6:0], sda_lvl};
                     bit_cnt  <= bit_cnt + 4'd1;
                  end else if (byte_end) begin
                     bit_cnt <= '0;
                     if (state == ST_DEV) begin
                        if (rx_shift[7:1] == DEV_CODE) begin
                           oe_q    <= 1'b1;
                           state   <= ST_DEV_ACK;
                           is_read <= rx_shift[0];
                           rd_req  <= rx_shift[0];
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_ADDR) begin
                        addr_ptr <= rx_shift[ADDR_W-1:0];
                        oe_q     <= 1'b1;
                        state    <= ST_ADDR_ACK;
                     end else begin
                        wr_q    <= 1'b1;
                        wdata_q <= rx_shift;
                        dirty   <= 1'b1;
                        oe_q    <= 1'b1;
                        state   <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (is_read) begin
                        oe_q  <= ~tx_shift[7];
                        state <= ST_RDATA;
                     end else begin
                        oe_q  <= 1'b0;
                        state <= ST_ADDR;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     oe_q  <= 1'b0;
                     state <= ST_WDATA;
                  end
               end
               ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     oe_q     <= 1'b0;
                     addr_ptr <= addr_ptr + ADDR_W'(1);
                     state    <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (byte_end) begin
                     bit_cnt <= '0;
                     oe_q    <= 1'b0;
                     state   <= ST_RACK;
                  end else if (scl_fall) begin
                     oe_q     <= ~tx_shift[6];
                     tx_shift <= {tx_shift[6:0], 1'b0};
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     addr_ptr <= addr_ptr + ADDR_W'(1);
                     got_ack  <= ~sda_lvl;
                     rd_req   <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (got_ack) begin
                        oe_q  <= ~tx_shift[7];
                        state <= ST_RDATA;
                     end else begin
                        state <= ST_WAIT_STOP;
                     end
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

   assign sda_oe      = oe_q;
   assign mem_addr    = addr_ptr;
   assign mem_wr_en   = wr_q;
   assign mem_wr_data = wdata_q;
   assign mem_rd_en   = rd_req;
   assign launch      = launch_q;

   assert_oe_moves_scl_low_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> !scl_lvl);

   assert_wr_one_cycle_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> !mem_wr_en);

   assert_no_rw_overlap_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_en && mem_rd_en));

   assert_quiet_while_busy_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!oe_q && !mem_wr_en));

   assert_standby_silent_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_STOP) |-> !oe_q);

endmodule

// File: rtl/eeb_slave_top.sv
module eeb_slave_top #(
   parameter logic [6:0] DEV_CODE     = 7'h50,
   parameter int         ADDR_W       = 8,
   parameter int         WRITE_CYCLES = 1000,
   parameter int         SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_wr_en_o,
   output logic [7:0]        mem_wr_data_o,
   output logic              mem_rd_en_o,
   input  logic [7:0]        mem_rd_data_i,
   output logic              busy_o
);

   initial begin
      assert (WRITE_CYCLES >= 0) else $error("eeb_slave_top: WRITE_CYCLES must not be negative");
   end

   localparam int LINES = 2;
   localparam int L_SCL = 0;
   localparam int L_SDA = 1;

   logic [LINES-1:0] raw;
   logic [LINES-1:0] lvl;
   logic [LINES-1:0] rise;
   logic [LINES-1:0] fall;
   logic             launch;
   logic             busy;

   assign raw = {sda_i, scl_i};

   for (genvar i = 0; i < LINES; i++) begin : g_line
      eeb_line_sync #(
         .STAGES    (SYNC_STAGES),
         .RESET_VAL (1'b1)
      ) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .din    (raw[i]),
         .lvl_o  (lvl[i]),
         .rise_o (rise[i]),
         .fall_o (fall[i])
      );
   end

   eeb_byte_engine #(
      .DEV_CODE (DEV_CODE),
      .ADDR_W   (ADDR_W)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_lvl     (lvl[L_SCL]),
      .scl_rise    (rise[L_SCL]),
      .scl_fall    (fall[L_SCL]),
      .sda_lvl     (lvl[L_SDA]),
      .sda_rise    (rise[L_SDA]),
      .sda_fall    (fall[L_SDA]),
      .busy        (busy),
      .sda_oe      (sda_oe_o),
      .mem_addr    (mem_addr_o),
      .mem_wr_en   (mem_wr_en_o),
      .mem_wr_data (mem_wr_data_o),
      .mem_rd_en   (mem_rd_en_o),
      .mem_rd_data (mem_rd_data_i),
      .launch      (launch)
   );

   if (WRITE_CYCLES > 0) begin : g_timer
      eeb_write_timer #(
         .CYCLES (WRITE_CYCLES)
      ) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .launch_i (launch),
         .busy_o   (busy)
      );
   end else begin : g_no_timer
      assign busy = 1'b0;
   end

   assign busy_o = busy;

endmodule

// File: tb/tb_eeb_slave_top.sv
module tb_eeb_slave_top;

   localparam int         CLK_PERIOD = 10;
   localparam int         HALF       = 16;
   localparam int         QTR        = 8;
   localparam logic [6:0] DEV        = 7'h50;
   localparam int         WCYC       = 1000;
   localparam logic [7:0] DEV_W      = {DEV, 1'b0};
   localparam logic [7:0] DEV_R      = {DEV, 1'b1};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sda;
   logic       sda_oe;
   logic [7:0] mem_addr;
   logic       mem_wr_en;
   logic [7:0] mem_wr_data;
   logic       mem_rd_en;
   logic [7:0] rd_q = 8'h00;
   logic       busy;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   int wr_pulses = 0;
   int rd_pulses = 0;
   int busy_cycles = 0;
   int oe_bad = 0;
   bit oe_seen = 1'b0;
   logic oe_prev = 1'b0;

   logic [7:0] mem_m [0:255];
   logic [7:0] exp_m [0:255];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda = ~(m_low | sda_oe);

   eeb_slave_top #(
      .DEV_CODE     (DEV),
      .ADDR_W       (8),
      .WRITE_CYCLES (WCYC),
      .SYNC_STAGES  (2)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (m_scl),
      .sda_i         (sda),
      .sda_oe_o      (sda_oe),
      .mem_addr_o    (mem_addr),
      .mem_wr_en_o   (mem_wr_en),
      .mem_wr_data_o (mem_wr_data),
      .mem_rd_en_o   (mem_rd_en),
      .mem_rd_data_i (rd_q),
      .busy_o        (busy)
   );

   always @(posedge clk) begin
      if (mem_wr_en) mem_m[mem_addr] <= mem_wr_data;
      if (mem_rd_en) rd_q <= mem_m[mem_addr];
   end

   always @(negedge clk) begin
      if (mem_wr_en) wr_pulses++;
      if (mem_rd_en) rd_pulses++;
      if (busy) busy_cycles++;
      if (sda_oe) oe_seen = 1'b1;
      if (sda_oe !== oe_prev && m_scl) oe_bad++;
      oe_prev = sda_oe;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_low = 1'b0; tick(QTR);
      m_scl = 1'b1; tick(QTR);
      m_low = 1'b1; tick(QTR);
      m_scl = 1'b0; tick(QTR);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tick(QTR);
      m_scl = 1'b1; tick(QTR);
      m_low = 1'b0; tick(QTR);
   endtask

   task automatic send_bit(input logic b);
      m_low = ~b; tick(QTR);
      m_scl = 1'b1; tick(HALF);
      m_scl = 1'b0; tick(QTR);
   endtask

   task automatic recv_bit(output logic b);
      m_low = 1'b0; tick(QTR);
      m_scl = 1'b1; tick(HALF/2);
      b = sda; tick(HALF/2);
      m_scl = 1'b0; tick(QTR);
   endtask

   task automatic write_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic read_byte(output logic [7:0] d, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~ack);
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      logic       ack;
      logic [7:0] d;
      int         w0;
      int         b0;

      for (int i = 0; i < 256; i++) begin
         mem_m[i] = 8'(i * 29 + 5);
         exp_m[i] = 8'(i * 29 + 5);
      end

      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R10: reset state
      check("R10 sda_oe", int'(sda_oe), 0);
      check("R10 busy", int'(busy), 0);
      check("R10 wr_en", int'(mem_wr_en), 0);
      check("R10 rd_en", int'(mem_rd_en), 0);

      // R1: a valid device byte without a start is not acknowledged
      write_byte(DEV_W, ack);
      check("R1 no start no ack", int'(ack), 0);
      bus_stop();

      // R2/R3: every single-bit corruption of the device code is rejected
      for (int b = 0; b < 7; b++) begin
         bus_start();
         write_byte({DEV ^ 7'(1 << b), 1'b0}, ack);
         check("R2 code mismatch nack", int'(ack), 0);
         if (b == 0) begin
            write_byte(8'h00, ack);
            check("R3 silent after mismatch", int'(ack), 0);
         end
         bus_stop();
      end

      // R3/R4: write four bytes across the top of the array
      w0 = wr_pulses;
      bus_start();
      write_byte(DEV_W, ack);
      check("R3 dev ack", int'(ack), 1);
      write_byte(8'hFE, ack);
      check("R3 addr ack", int'(ack), 1);
      for (int k = 0; k < 4; k++) begin
         write_byte(8'(k * 37 + 11), ack);
         check("R3 data ack", int'(ack), 1);
         exp_m[8'(8'hFE + k)] = 8'(k * 37 + 11);
      end
      check("R4 write strobes", wr_pulses - w0, 4);
      check("R4 wrap FE", int'(mem_m[8'hFE]), int'(exp_m[8'hFE]));
      check("R4 wrap 01", int'(mem_m[8'h01]), int'(exp_m[8'h01]));
      b0 = busy_cycles;
      bus_stop();
      check("R7 busy after write stop", int'(busy), 1);

      // R8: bus ignored during the write cycle
      w0 = wr_pulses;
      bus_start();
      write_byte(DEV_W, ack);
      check("R8 no ack while busy", int'(ack), 0);
      bus_stop();
      check("R8 no strobe while busy", wr_pulses - w0, 0);
      check("R8 still busy", int'(busy), 1);
      while (busy) tick(1);
      check("R7 busy length", busy_cycles - b0, WCYC);

      // R5/R9/R6: random read via address write and repeated start
      bus_start();
      write_byte(DEV_W, ack);
      write_byte(8'hFE, ack);
      bus_start();
      write_byte(DEV_R, ack);
      check("R9 repeated start dev ack", int'(ack), 1);
      for (int k = 0; k < 5; k++) begin
         read_byte(d, k < 4);
         check("R5 read data", int'(d), int'(exp_m[8'(8'hFE + k)]));
      end
      oe_seen = 1'b0;
      for (int k = 0; k < 9; k++) begin
         logic b;
         recv_bit(b);
      end
      check("R6 standby after nack", int'(oe_seen), 0);
      bus_stop();
      tick(20);
      check("R7 no busy without data", int'(busy), 0);

      // R5: current address read continues after the previous pointer
      bus_start();
      write_byte(DEV_R, ack);
      read_byte(d, 1'b1);
      check("R5 current read 03", int'(d), int'(exp_m[8'h03]));
      read_byte(d, 1'b0);
      check("R5 current read 04", int'(d), int'(exp_m[8'h04]));
      bus_stop();

      // R9: repeated start part way through a data byte
      w0 = wr_pulses;
      bus_start();
      write_byte(DEV_W, ack);
      write_byte(8'h40, ack);
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b0);
      bus_start();
      write_byte(DEV_W, ack);
      check("R9 dev ack after mid-byte start", int'(ack), 1);
      write_byte(8'h80, ack);
      write_byte(8'h5A, ack);
      exp_m[8'h80] = 8'h5A;
      bus_stop();
      check("R9 single strobe", wr_pulses - w0, 1);
      while (busy) tick(1);

      // R5: sweep read of the whole array from address 0
      bus_start();
      write_byte(DEV_W, ack);
      write_byte(8'h00, ack);
      bus_start();
      write_byte(DEV_R, ack);
      for (int a = 0; a < 256; a++) begin
         read_byte(d, a < 255);
         check("R5 sweep", int'(d), int'(exp_m[a]));
      end
      bus_stop();
      check("R5 drive only with scl low", oe_bad, 0);

      done = 1'b1;
      report();
      $finish;
   end

endmodule